// File: doc/BRIEF.md
# Multi-Core Interrupt Distributor

The block gathers interrupt sources for a small multi-core cluster and decides, for each CPU interface, which of them are currently forwarded. Three kinds of source exist. Sixteen software-raised IDs (0 to 15) and sixteen private peripheral IDs (16 to 31) are kept separately for each CPU. Every ID from 32 up to `NUM_IRQ-1` is a shared line, and it can be routed to any subset of CPUs through a 16-bit target field.

Software programs the block over a plain 32-bit register bus. Each access carries the index of the issuing CPU, which selects the bank for the private IDs. Enables are changed only through separate set and clear words. Each source has a two-bit trigger mode. A single control bit gates all forwarding. A dedicated write register raises a software interrupt on a list of CPUs. Each CPU interface returns an acknowledge with an ID, which retires latched edge pending state. Priority arbitration between forwarded IDs is left to the CPU interfaces.

Top module: `intdist`

## Requirements
- R1: Writing a one to bit `n%32` of word `0x100 + 4*(n/32)` enables ID `n`, and writing a one to the same bit of word `0x180 + 4*(n/32)` disables it. Zero bits change nothing. Reading either word returns the current enable bits.
- R2: For IDs 0 to 31, the enable bits and the pending bits belong to the bank selected by `bus_cpu`. A write by one CPU is not visible in another CPU's bank.
- R3: Shared ID `n` has a 16-bit target field in word `0x400 + ((2*n) & ~3)` at bit shift `16*(n%2)`, with bit `c` selecting CPU `c`. Field bits at `NUM_CPU` and above read as zero.
- R4: Reading a target word of an ID below 32 returns `1<<bus_cpu` in both 16-bit halves. Writes to those words are ignored.
- R5: ID `n` has a trigger field at word `0x300 + 4*(n/16)`, bits `[2*(n%16)+1 : 2*(n%16)]`. The codes are 00 level-high, 01 level-low, 10 rising edge and 11 falling edge, and every field resets to 00. The fields of IDs 0 to 15 always read 10, and writes to them are ignored. A field write for an ID of 32 or above whose low bit is 1 is ignored, so the field keeps its old code.
- R6: A level-triggered source is pending exactly while its input was at the active level at the previous clock edge. An acknowledge has no effect on it.
- R7: An edge-triggered source becomes pending one edge after an active transition of its input. It stays pending until an acknowledge carrying its ID arrives: from any CPU for a shared ID, and from the owning CPU for a private ID.
- R8: A write to `0xF00` raises software ID `wdata[3:0]` pending on every CPU `c` whose bit `wdata[8+c]` is set. The ID then stays pending until that CPU acknowledges it.
- R9: The read-only word `0x004` returns `NUM_IRQ/32 - 1` in bits [4:0] and zero elsewhere.
- R10: Control bit 0 at `0x000` resets to 0. While it is 0, no interrupt is forwarded to any CPU.
- R11: `irq_fwd[c*NUM_IRQ + n]` is high when ID `n` is pending, enabled and targeted at CPU `c`, and the control bit is set. Private IDs always target their own CPU.
- R12: Word `0x200 + 4*(n/32)` reads the pending bits, with word 0 taken from the bank of `bus_cpu`. Read data appears on `bus_rdata` after the clock edge at which `bus_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_cpu | input | CPU_W | Index of the CPU issuing the access |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ppi_in | input | 16*NUM_CPU | Private peripheral lines, CPU c in bits [16c+15:16c] |
| spi_in | input | NUM_IRQ-32 | Shared lines, bit s is ID 32+s |
| ack_valid | input | NUM_CPU | Acknowledge strobe per CPU interface |
| ack_id | input | NUM_CPU*ID_W | Acknowledged ID per CPU interface |
| irq_fwd | output | NUM_CPU*NUM_IRQ | Forwarded interrupts, CPU c in bits [c*NUM_IRQ +: NUM_IRQ] |

## Verification
The assertions assume that `bus_cpu` always names an existing CPU and that `NUM_CPU` is a power of two no larger than 16. They also assume that the trigger mode of a source stays fixed while its pending state is being judged. The bench keeps to these limits. It reprograms a trigger field only while that source's input is idle, issues writes and acknowledges one per cycle between clock edges, and drives `bus_cpu` only with indices 0 to 3.

// File: rtl/intdist_pkg.sv
package intdist_pkg;
    // Register byte offsets
    localparam logic [11:0] OFS_CTRL  = 12'h000;
    localparam logic [11:0] OFS_TYPE  = 12'h004;
    localparam logic [11:0] OFS_ENSET = 12'h100;
    localparam logic [11:0] OFS_ENCLR = 12'h180;
    localparam logic [11:0] OFS_PEND  = 12'h200;
    localparam logic [11:0] OFS_CFG   = 12'h300;
    localparam logic [11:0] OFS_TGT   = 12'h400;
    localparam logic [11:0] OFS_SGI   = 12'hF00;

    localparam int PRIV_IDS = 32;
    localparam int SGI_IDS  = 16;

    // Two-bit trigger code: bit1 = edge, bit0 = active-low / falling
    typedef enum logic [1:0] {
        TRIG_LVL_HI    = 2'b00,
        TRIG_LVL_LO    = 2'b01,
        TRIG_EDGE_RISE = 2'b10,
        TRIG_EDGE_FALL = 2'b11
    } trig_e;
endpackage

// File: rtl/intdist_line.sv
// One interrupt source: trigger conversion and pending state.
// Assumes cfg_i is held steady while the input is active.
module intdist_line (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_i,
    input  logic [1:0] cfg_i,
    input  logic       ack_i,
    input  logic       sw_set_i,
    output logic       pend_o
);
    logic act, act_q, edge_pend;

    assign act = line_i ^ cfg_i[0];

    // Sample the polarity-corrected input
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= 1'b0;
        else        act_q <= act;
    end

    // Latch edges and software raises; acknowledge retires them, a new edge wins
    always_ff @(posedge clk) begin
        if (!rst_n) edge_pend <= 1'b0;
        else        edge_pend <= (cfg_i[1] & ((edge_pend & ~ack_i) | (act & ~act_q))) | sw_set_i;
    end

    assign pend_o = cfg_i[1] ? edge_pend : act_q;

    // R7: latched pending survives until acknowledged
    a_r7_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[1] && $past(rst_n) && $past(cfg_i[1]) && $past(pend_o) && !$past(ack_i)) |-> pend_o);

    // R8: a software raise shows as pending on the next edge
    a_r8_sw_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[1] && $past(rst_n) && $past(sw_set_i)) |-> pend_o);
endmodule

// File: rtl/intdist_route.sv
// Forwarding gate: per CPU, pending AND enabled AND targeted AND global enable.
// Assumes the vectors are laid out CPU-major, NUM_IRQ bits per CPU.
module intdist_route #(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4
) (
    input  logic                       gate_i,
    input  logic [NUM_CPU*NUM_IRQ-1:0] pend_i,
    input  logic [NUM_CPU*NUM_IRQ-1:0] en_i,
    input  logic [NUM_CPU*NUM_IRQ-1:0] tgt_i,
    output logic [NUM_CPU*NUM_IRQ-1:0] fwd_o
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        // Combine the four conditions for CPU c
        assign fwd_o[c*NUM_IRQ +: NUM_IRQ] = {NUM_IRQ{gate_i}} & pend_i[c*NUM_IRQ +: NUM_IRQ]
                                           & en_i[c*NUM_IRQ +: NUM_IRQ] & tgt_i[c*NUM_IRQ +: NUM_IRQ];
    end
endmodule

// File: rtl/intdist.sv
// Interrupt distributor top: register file, source array and routing.
// Assumes NUM_IRQ is a multiple of 32 (64..480), NUM_CPU a power of two <= 16,
// and bus_cpu always below NUM_CPU.
module intdist
    import intdist_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int NUM_CPU = 4,
    localparam int ID_W  = $clog2(NUM_IRQ),
    localparam int CPU_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [CPU_W-1:0]           bus_cpu,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [11:0]                bus_addr,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    input  logic [16*NUM_CPU-1:0]      ppi_in,
    input  logic [NUM_IRQ-33:0]        spi_in,
    input  logic [NUM_CPU-1:0]         ack_valid,
    input  logic [NUM_CPU*ID_W-1:0]    ack_id,
    output logic [NUM_CPU*NUM_IRQ-1:0] irq_fwd
);
    localparam int NUM_WORDS = NUM_IRQ / 32;
    localparam int NUM_SPI   = NUM_IRQ - PRIV_IDS;

    logic                        ctrl_en;
    logic [31:0]                 en_priv [NUM_CPU];
    logic [NUM_SPI-1:0]          en_spi;
    logic [1:0]                  cfg_ppi [SGI_IDS];
    logic [1:0]                  cfg_spi [NUM_SPI];
    logic [NUM_CPU-1:0]          tgt_spi [NUM_SPI];
    logic [NUM_CPU-1:0][15:0]    sgi_pend, ppi_pend;
    logic [NUM_SPI-1:0]          spi_pend, spi_ack;
    logic [NUM_CPU*NUM_IRQ-1:0]  pend_all, en_all, tgt_all;
    logic [31:0]                 rd_word;
    logic                        sgi_hit;

    assign sgi_hit = bus_wr && (bus_addr == OFS_SGI);

    // Private sources, one bank per CPU
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_bank
        for (genvar i = 0; i < SGI_IDS; i++) begin : g_id
            intdist_line u_sgi (
                .clk(clk), .rst_n(rst_n), .line_i(1'b0), .cfg_i(TRIG_EDGE_RISE),
                .ack_i(ack_valid[c] && ack_id[c*ID_W +: ID_W] == ID_W'(i)),
                .sw_set_i(sgi_hit && bus_wdata[8+c] && bus_wdata[3:0] == 4'(i)),
                .pend_o(sgi_pend[c][i]));
            intdist_line u_ppi (
                .clk(clk), .rst_n(rst_n), .line_i(ppi_in[c*16+i]), .cfg_i(cfg_ppi[i]),
                .ack_i(ack_valid[c] && ack_id[c*ID_W +: ID_W] == ID_W'(SGI_IDS+i)),
                .sw_set_i(1'b0), .pend_o(ppi_pend[c][i]));
        end
    end

    // Any CPU acknowledging a shared ID retires it
    always_comb begin
        spi_ack = '0;
        for (int s = 0; s < NUM_SPI; s++)
            for (int c = 0; c < NUM_CPU; c++)
                if (ack_valid[c] && ack_id[c*ID_W +: ID_W] == ID_W'(PRIV_IDS+s)) spi_ack[s] = 1'b1;
    end

    for (genvar s = 0; s < NUM_SPI; s++) begin : g_spi
        intdist_line u_spi (
            .clk(clk), .rst_n(rst_n), .line_i(spi_in[s]), .cfg_i(cfg_spi[s]),
            .ack_i(spi_ack[s]), .sw_set_i(1'b0), .pend_o(spi_pend[s]));
    end

    // Build the per-CPU pending, enable and target views
    always_comb begin
        for (int c = 0; c < NUM_CPU; c++) begin
            pend_all[c*NUM_IRQ +: NUM_IRQ] = {spi_pend, ppi_pend[c], sgi_pend[c]};
            en_all[c*NUM_IRQ +: NUM_IRQ]   = {en_spi, en_priv[c]};
            for (int n = 0; n < PRIV_IDS; n++) tgt_all[c*NUM_IRQ+n] = 1'b1;
            for (int s = 0; s < NUM_SPI; s++) tgt_all[c*NUM_IRQ+PRIV_IDS+s] = tgt_spi[s][c];
        end
    end

    intdist_route #(.NUM_IRQ(NUM_IRQ), .NUM_CPU(NUM_CPU)) u_route (
        .gate_i(ctrl_en), .pend_i(pend_all), .en_i(en_all), .tgt_i(tgt_all), .fwd_o(irq_fwd));

    // Register writes: control, enable set/clear, trigger and target fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_en <= 1'b0;
            en_spi  <= '0;
            for (int c = 0; c < NUM_CPU; c++) en_priv[c] <= '0;
            for (int i = 0; i < SGI_IDS; i++) cfg_ppi[i] <= TRIG_LVL_HI;
            for (int s = 0; s < NUM_SPI; s++) begin
                cfg_spi[s] <= TRIG_LVL_HI;
                tgt_spi[s] <= '0;
            end
        end else if (bus_wr) begin
            if (bus_addr == OFS_CTRL)  ctrl_en <= bus_wdata[0];
            if (bus_addr == OFS_ENSET) en_priv[bus_cpu] <= en_priv[bus_cpu] | bus_wdata;
            if (bus_addr == OFS_ENCLR) en_priv[bus_cpu] <= en_priv[bus_cpu] & ~bus_wdata;
            for (int w = 1; w < NUM_WORDS; w++) begin
                if (bus_addr == OFS_ENSET + 12'(4*w))
                    en_spi[(w-1)*32 +: 32] <= en_spi[(w-1)*32 +: 32] | bus_wdata;
                if (bus_addr == OFS_ENCLR + 12'(4*w))
                    en_spi[(w-1)*32 +: 32] <= en_spi[(w-1)*32 +: 32] & ~bus_wdata;
            end
            for (int i = 0; i < SGI_IDS; i++)
                if (bus_addr == OFS_CFG + 12'd4) cfg_ppi[i] <= bus_wdata[2*i +: 2];
            for (int s = 0; s < NUM_SPI; s++) begin
                if (bus_addr == OFS_CFG + 12'(4*((PRIV_IDS+s)/16)) && !bus_wdata[2*((PRIV_IDS+s)%16)])
                    cfg_spi[s] <= bus_wdata[2*((PRIV_IDS+s)%16) +: 2];
                if (bus_addr == OFS_TGT + 12'(((PRIV_IDS+s)*2) & ~3))
                    tgt_spi[s] <= bus_wdata[16*((PRIV_IDS+s)%2) +: NUM_CPU];
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rd_word = '0;
        if (bus_addr == OFS_CTRL) rd_word[0] = ctrl_en;
        if (bus_addr == OFS_TYPE) rd_word[4:0] = 5'(NUM_WORDS-1);
        if (bus_addr == OFS_ENSET || bus_addr == OFS_ENCLR) rd_word = en_priv[bus_cpu];
        if (bus_addr == OFS_PEND) rd_word = {ppi_pend[bus_cpu], sgi_pend[bus_cpu]};
        for (int w = 1; w < NUM_WORDS; w++) begin
            if (bus_addr == OFS_ENSET + 12'(4*w) || bus_addr == OFS_ENCLR + 12'(4*w))
                rd_word = en_spi[(w-1)*32 +: 32];
            if (bus_addr == OFS_PEND + 12'(4*w)) rd_word = spi_pend[(w-1)*32 +: 32];
        end
        if (bus_addr == OFS_CFG) rd_word = {16{TRIG_EDGE_RISE}};
        for (int i = 0; i < SGI_IDS; i++)
            if (bus_addr == OFS_CFG + 12'd4) rd_word[2*i +: 2] = cfg_ppi[i];
        for (int s = 0; s < NUM_SPI; s++) begin
            if (bus_addr == OFS_CFG + 12'(4*((PRIV_IDS+s)/16)))
                rd_word[2*((PRIV_IDS+s)%16) +: 2] = cfg_spi[s];
            if (bus_addr == OFS_TGT + 12'(((PRIV_IDS+s)*2) & ~3))
                rd_word[16*((PRIV_IDS+s)%2) +: NUM_CPU] = tgt_spi[s];
        end
        for (int w = 0; w < PRIV_IDS/2; w++)
            if (bus_addr == OFS_TGT + 12'(4*w)) begin
                rd_word[int'(bus_cpu)]      = 1'b1;
                rd_word[16 + int'(bus_cpu)] = 1'b1;
            end
    end

    // Register the read data
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_word;
    end

    // R10: nothing is forwarded while the global enable is off
    a_r10_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |-> (irq_fwd == '0));

    // R4: a private target read yields one identical CPU bit in each half
    a_r4_priv_tgt: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == OFS_TGT) |=>
        ($countones(bus_rdata) == 2 && bus_rdata[15:0] == bus_rdata[31:16]));

    for (genvar s = 0; s < NUM_SPI; s++) begin : g_chk
        // R1: a shared enable only rises after a set write with that bit
        a_r1_set_only: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(en_spi[s])) |->
            $past(bus_wr && bus_addr == OFS_ENSET + 12'(4*((PRIV_IDS+s)/32)) && bus_wdata[(PRIV_IDS+s)%32]));
        // R1: a shared enable only falls after a clear write with that bit
        a_r1_clr_only: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $fell(en_spi[s])) |->
            $past(bus_wr && bus_addr == OFS_ENCLR + 12'(4*((PRIV_IDS+s)/32)) && bus_wdata[(PRIV_IDS+s)%32]));
        // R5: shared sources never hold a low-level or falling-edge code
        a_r5_spi_modes: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_spi[s][0] == 1'b0);
    end
endmodule

// File: tb/intdist_bench.sv
module intdist_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NI = 64;
    localparam int NC = 4;
    localparam int IW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      bus_cpu = '0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0]     bus_addr = '0;
    logic [31:0]     bus_wdata = '0, bus_rdata;
    logic [16*NC-1:0] ppi_in = '0;
    logic [NI-33:0]  spi_in = '0;
    logic [NC-1:0]   ack_valid = '0;
    logic [NC*IW-1:0] ack_id = '0;
    logic [NC*NI-1:0] irq_fwd;

    int n_run = 0, n_fail = 0;
    logic [31:0] rv;

    always #(CLK_PERIOD/2) clk = ~clk;

    intdist #(.NUM_IRQ(NI), .NUM_CPU(NC)) u_intdist (
        .clk(clk), .rst_n(rst_n), .bus_cpu(bus_cpu), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ppi_in(ppi_in), .spi_in(spi_in), .ack_valid(ack_valid), .ack_id(ack_id),
        .irq_fwd(irq_fwd));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int cpu, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int cpu, input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_cpu = 2'(cpu); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic ack(input int cpu, input int id);
        @(negedge clk);
        ack_valid[cpu] = 1'b1; ack_id[cpu*IW +: IW] = IW'(id);
        @(negedge clk);
        ack_valid[cpu] = 1'b0;
    endtask

    function automatic logic fwd(input int cpu, input int id);
        return irq_fwd[cpu*NI + id];
    endfunction

    task automatic t_reset;
        rd(0, 12'h000, rv); check("R10 ctrl reset", rv, 32'h0);
        rd(0, 12'h004, rv); check("R9 type", rv, 32'h1);
        rd(0, 12'h104, rv); check("R1 enable reset", rv, 32'h0);
        rd(0, 12'h300, rv); check("R5 sgi cfg", rv, 32'hAAAA_AAAA);
        check("R10 fwd reset", {31'b0, |irq_fwd}, 32'h0);
    endtask

    task automatic t_enable;
        wr(0, 12'h104, 32'h5); rd(0, 12'h104, rv); check("R1 set", rv, 32'h5);
        wr(0, 12'h104, 32'h2); rd(0, 12'h184, rv); check("R1 set accum", rv, 32'h7);
        wr(0, 12'h184, 32'h1); rd(0, 12'h104, rv); check("R1 clear", rv, 32'h6);
        wr(0, 12'h184, 32'h0); rd(0, 12'h104, rv); check("R1 zero write", rv, 32'h6);
        wr(0, 12'h184, 32'hFFFF_FFFF);
    endtask

    task automatic t_banked;
        wr(0, 12'h100, 32'h0001_0020);
        rd(1, 12'h100, rv); check("R2 other bank", rv, 32'h0);
        rd(0, 12'h100, rv); check("R2 own bank", rv, 32'h0001_0020);
        wr(0, 12'h180, 32'hFFFF_FFFF);
    endtask

    task automatic t_target;
        wr(0, 12'h440, 32'hFFFF_0003); rd(0, 12'h440, rv); check("R3 tgt 32/33", rv, 32'h000F_0003);
        wr(0, 12'h47C, 32'h0008_0000); rd(0, 12'h47C, rv); check("R3 tgt 63", rv, 32'h0008_0000);
    endtask

    task automatic t_priv_tgt;
        rd(2, 12'h400, rv); check("R4 cpu2 mask", rv, 32'h0004_0004);
        wr(0, 12'h41C, 32'h0);
        rd(1, 12'h41C, rv); check("R4 write ignored", rv, 32'h0002_0002);
    endtask

    task automatic t_cfg;
        wr(0, 12'h300, 32'h0); rd(0, 12'h300, rv); check("R5 sgi cfg fixed", rv, 32'hAAAA_AAAA);
        wr(0, 12'h308, 32'h6); rd(0, 12'h308, rv); check("R5 spi low-code ignored", rv, 32'h2);
        wr(0, 12'h308, 32'h3); rd(0, 12'h308, rv); check("R5 spi keeps edge", rv, 32'h2);
        wr(0, 12'h304, 32'h1); rd(0, 12'h304, rv); check("R5 ppi level-low", rv, 32'h1);
        wr(0, 12'h304, 32'h0);
    endtask

    task automatic t_level;
        wr(0, 12'h000, 32'h1);
        wr(0, 12'h104, 32'h100);
        wr(0, 12'h450, 32'h2);
        @(negedge clk); spi_in[8] = 1'b1;
        @(negedge clk);
        check("R6 level fwd cpu1", {31'b0, fwd(1, 40)}, 32'h1);
        check("R11 untargeted cpu0", {31'b0, fwd(0, 40)}, 32'h0);
        ack(1, 40);
        check("R6 ack no effect", {31'b0, fwd(1, 40)}, 32'h1);
        spi_in[8] = 1'b0;
        @(negedge clk);
        check("R6 level drop", {31'b0, fwd(1, 40)}, 32'h0);
    endtask

    task automatic t_edge;
        wr(0, 12'h104, 32'h1);
        @(negedge clk); spi_in[0] = 1'b1;
        @(negedge clk); spi_in[0] = 1'b0;
        @(negedge clk);
        check("R7 edge held cpu0", {31'b0, fwd(0, 32)}, 32'h1);
        check("R7 edge held cpu1", {31'b0, fwd(1, 32)}, 32'h1);
        rd(2, 12'h204, rv); check("R12 spi pending", rv, 32'h1);
        ack(3, 32);
        check("R7 ack clears", {31'b0, fwd(0, 32)}, 32'h0);
        rd(0, 12'h204, rv); check("R12 pending cleared", rv, 32'h0);
    endtask

    task automatic t_sgi;
        wr(0, 12'hF00, 32'h0000_0A05);
        rd(1, 12'h200, rv); check("R8 sgi cpu1", rv, 32'h20);
        rd(0, 12'h200, rv); check("R8 unlisted cpu0", rv, 32'h0);
        wr(3, 12'h100, 32'h20);
        @(negedge clk);
        check("R11 sgi fwd cpu3", {31'b0, fwd(3, 5)}, 32'h1);
        check("R2 cpu1 not enabled", {31'b0, fwd(1, 5)}, 32'h0);
        ack(1, 5);
        rd(1, 12'h200, rv); check("R8 ack cpu1", rv, 32'h0);
        rd(3, 12'h200, rv); check("R2 cpu3 still pending", rv, 32'h20);
    endtask

    task automatic t_gate;
        wr(0, 12'h000, 32'h0);
        @(negedge clk);
        check("R10 gate off", {31'b0, fwd(3, 5)}, 32'h0);
        rd(0, 12'h000, rv); check("R10 ctrl readback", rv, 32'h0);
        wr(0, 12'h000, 32'h1);
        @(negedge clk);
        check("R10 gate on", {31'b0, fwd(3, 5)}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_enable;
        t_banked;
        t_target;
        t_priv_tgt;
        t_cfg;
        t_level;
        t_edge;
        t_sgi;
        t_gate;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule